// File: doc/BRIEF.md
# Latched Fault and Link Status Registers for a Four-Lane Extender Sublayer

This block holds the management status of a four-lane 10-gigabit extender sublayer. It watches live condition inputs: a synchronization flag per lane, a cross-lane alignment flag, a transmit-path fault flag and an implementation-defined receive error flag. From these it keeps three readable 16-bit registers. The first holds a receive link-up bit and a summary fault bit. The second holds latched receive and transmit local-fault bits. The third is a live snapshot of lane synchronization and alignment.

The link-up bit latches low and the local-fault bits latch high. Each latched bit is cleared only by a read of its own register, and after that read it reloads from the live condition. Link-up and receive fault both describe one receive condition with opposite sense, but they sit in different registers and are cleared by different reads, so at a given time they can disagree. A host reads a register by pulsing `rd_en` with an address. The word appears on `rd_data` one cycle later.

Top module: `xs_mgmt_status`

## Requirements
- R1: During reset and until the first read of each register, `rd_data` is 0, the link-up bit (address 1, bit 2) reads 0 and both fault bits (address 8, bits 10 and 11) read 1.
- R2: The live receive fault condition is true when any of the four `lane_sync` bits is 0, when `lanes_aligned` is 0, or when `rx_err_in` is 1. A single cycle of any of these is captured.
- R3: The link-up bit (address 1, bit 2) latches low. After any cycle with a live receive fault it reads 0 until address 1 is read. That read returns the latched value and reloads the bit from the live state.
- R4: The receive fault bit (address 8, bit 10) and the transmit fault bit (address 8, bit 11, set by `tx_fault_in`) latch high. A read of address 8 returns the latched values and reloads both bits from the live state.
- R5: If a fault (or a link drop) is live in the same cycle as the clearing read, the bit stays latched for the next read.
- R6: The summary bit (address 1, bit 7) reads as the OR of the latched receive and transmit fault bits. A read of address 1 does not clear those fault bits.
- R7: Each latched bit is cleared only by a read of its own register. After a transient receive fault, link-up can read 1 while the receive fault bit still reads 1.
- R8: Address 24 is live and not latched. Bits 3:0 hold `lane_sync` (lane n in bit n) and bit 12 holds `lanes_aligned`, both as sampled in the read cycle. `rx_err_in` does not affect it, and reading it clears nothing.
- R9: Unused bits of every register read 0, and any address other than 1, 8 or 24 returns 0.
- R10: `rd_data` is registered. It updates in the cycle after a cycle with `rd_en` high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lane_sync | input | 4 | Live per-lane synchronization flags |
| lanes_aligned | input | 1 | Live cross-lane alignment flag |
| tx_fault_in | input | 1 | Live transmit-path local fault |
| rx_err_in | input | 1 | Implementation-defined receive error |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rd_addr | input | 5 | Register address |
| rd_data | output | 16 | Read data, valid the cycle after `rd_en` |

## Verification
The bench targets four kinds of mistake.

- **Event during a clearing read.** The bench raises a fault in the very cycle of the clearing read. A design that gave the clear priority would lose that fault, and the following read would come back clean.
- **Transient receive fault.** After a one-cycle fault, the bench reads the two registers in turn. A design that cleared both receive bits on either read, or that derived link-up from the fault bit, would show the two bits as inverses and never in disagreement.
- **Error flag versus lane snapshot.** The bench asserts the receive error flag alone. A design that folded it into the alignment snapshot would drop bit 12, and one that ignored it would never latch a receive fault.
- **Holding and unused addresses.** Random traffic checks that reads of unused addresses return 0 and that `rd_data` holds between reads.

// File: rtl/xs_status_pkg.sv
// Shared address and bit-position constants for the extender status block.
// Assumes a 16-bit register word; positions are fixed by the register map.
package xs_status_pkg;
    localparam int STAT1_ADDR   = 1;
    localparam int STAT2_ADDR   = 8;
    localparam int LANE_ADDR    = 24;
    localparam int LINK_UP_BIT  = 2;
    localparam int SUMMARY_BIT  = 7;
    localparam int RX_FAULT_BIT = 10;
    localparam int TX_FAULT_BIT = 11;
    localparam int ALIGN_BIT    = 12;
endpackage

// File: rtl/xs_sticky_bit.sv
// One latched status bit. LATCH_HIGH=1 keeps a 1 once seen; LATCH_HIGH=0
// keeps a 0 once seen. A clear reloads the bit from the live value, so a
// live event in the clear cycle survives. Assumes clr is a one-cycle strobe.
module xs_sticky_bit #(
    parameter bit LATCH_HIGH = 1'b1,
    parameter bit RESET_VAL  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic live,
    input  logic clr,
    output logic q
);
    logic q_next;

    generate
        if (LATCH_HIGH) begin : g_high
            // Sticky-one: accumulate ones until cleared.
            always_comb q_next = clr ? live : (q | live);
        end else begin : g_low
            // Sticky-zero: accumulate zeros until cleared.
            always_comb q_next = clr ? live : (q & live);
        end
    endgenerate

    // Register the latched state with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= RESET_VAL;
        else        q <= q_next;
    end
endmodule

// File: rtl/xs_fault_eval.sv
// Derives the live receive condition from lane sync, alignment and the
// implementation-defined error input. Purely combinational.
module xs_fault_eval #(
    parameter int LANES = 4
) (
    input  logic [LANES-1:0] lane_sync,
    input  logic             lanes_aligned,
    input  logic             rx_err_in,
    output logic             rx_fault_live,
    output logic             link_up_live
);
    // Fault when any lane is out of sync, alignment fails, or error reported.
    always_comb begin
        rx_fault_live = !(&lane_sync) || !lanes_aligned || rx_err_in;
        link_up_live  = !rx_fault_live;
    end
endmodule

// File: rtl/xs_reg_read.sv
// Assembles the addressed 16-bit word from latched and live state.
// Unused bits and unknown addresses give 0. Combinational.
module xs_reg_read
    import xs_status_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              link_up_q,
    input  logic              rx_fault_q,
    input  logic              tx_fault_q,
    input  logic [LANES-1:0]  lane_sync,
    input  logic              lanes_aligned,
    output logic [DATA_W-1:0] word
);
    // Select and pack the register addressed this cycle.
    always_comb begin
        word = '0;
        if (addr == ADDR_W'(STAT1_ADDR)) begin
            word[LINK_UP_BIT] = link_up_q;
            word[SUMMARY_BIT] = rx_fault_q | tx_fault_q;
        end else if (addr == ADDR_W'(STAT2_ADDR)) begin
            word[RX_FAULT_BIT] = rx_fault_q;
            word[TX_FAULT_BIT] = tx_fault_q;
        end else if (addr == ADDR_W'(LANE_ADDR)) begin
            word[LANES-1:0] = lane_sync;
            word[ALIGN_BIT] = lanes_aligned;
        end
    end
endmodule

// File: rtl/xs_mgmt_status.sv
// Management status top for a four-lane extender sublayer. Keeps a latched
// link-up bit, latched receive/transmit fault bits and a live lane word.
// Reads return the pre-read state one cycle later and clear the register read.
// Assumes inputs are synchronous to clk and rd_en is a per-read strobe.
module xs_mgmt_status
    import xs_status_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANES-1:0]  lane_sync,
    input  logic              lanes_aligned,
    input  logic              tx_fault_in,
    input  logic              rx_err_in,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic rx_fault_live, link_up_live;
    logic link_up_q, rx_fault_q, tx_fault_q;
    logic clr_stat1, clr_stat2;
    logic [DATA_W-1:0] word;

    // Decode the clearing side effect of a read.
    always_comb begin
        clr_stat1 = rd_en && (rd_addr == ADDR_W'(STAT1_ADDR));
        clr_stat2 = rd_en && (rd_addr == ADDR_W'(STAT2_ADDR));
    end

    xs_fault_eval #(.LANES(LANES)) u_eval (
        .lane_sync     (lane_sync),
        .lanes_aligned (lanes_aligned),
        .rx_err_in     (rx_err_in),
        .rx_fault_live (rx_fault_live),
        .link_up_live  (link_up_live)
    );

    xs_sticky_bit #(.LATCH_HIGH(1'b0), .RESET_VAL(1'b0)) u_link (
        .clk(clk), .rst_n(rst_n), .live(link_up_live), .clr(clr_stat1), .q(link_up_q)
    );
    xs_sticky_bit #(.LATCH_HIGH(1'b1), .RESET_VAL(1'b1)) u_rxf (
        .clk(clk), .rst_n(rst_n), .live(rx_fault_live), .clr(clr_stat2), .q(rx_fault_q)
    );
    xs_sticky_bit #(.LATCH_HIGH(1'b1), .RESET_VAL(1'b1)) u_txf (
        .clk(clk), .rst_n(rst_n), .live(tx_fault_in), .clr(clr_stat2), .q(tx_fault_q)
    );

    xs_reg_read #(.LANES(LANES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_read (
        .addr          (rd_addr),
        .link_up_q     (link_up_q),
        .rx_fault_q    (rx_fault_q),
        .tx_fault_q    (tx_fault_q),
        .lane_sync     (lane_sync),
        .lanes_aligned (lanes_aligned),
        .word          (word)
    );

    // Capture the read word on a strobe and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= word;
    end
endmodule

// File: rtl/xs_mgmt_status_chk.sv
// Port-level checker for xs_mgmt_status, attached with bind below.
module xs_mgmt_status_chk
    import xs_status_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [LANES-1:0]  lane_sync,
    input logic              lanes_aligned,
    input logic              tx_fault_in,
    input logic              rx_err_in,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data
);
    logic is_s1, is_s2, is_ln, is_unused;

    // Classify the addressed register.
    always_comb begin
        is_s1     = rd_addr == ADDR_W'(STAT1_ADDR);
        is_s2     = rd_addr == ADDR_W'(STAT2_ADDR);
        is_ln     = rd_addr == ADDR_W'(LANE_ADDR);
        is_unused = !is_s1 && !is_s2 && !is_ln;
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data)); // R10
    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && is_unused |=> rd_data == '0); // R9
    AST_LANE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && is_ln |=> rd_data[LANES-1:0] == $past(lane_sync)
                           && rd_data[ALIGN_BIT] == $past(lanes_aligned)); // R8
    AST_RXF_CAUGHT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && is_s2 && $past(rx_err_in) |=> rd_data[RX_FAULT_BIT]); // R2
    AST_TXF_CAUGHT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && is_s2 && $past(tx_fault_in) |=> rd_data[TX_FAULT_BIT]); // R4
    AST_LINK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && is_s1 && !$past(&lane_sync) |=> !rd_data[LINK_UP_BIT]); // R3
    AST_SUMMARY_TX: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && is_s1 && $past(tx_fault_in) |=> rd_data[SUMMARY_BIT]); // R6
endmodule

bind xs_mgmt_status xs_mgmt_status_chk #(
    .LANES(LANES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .lane_sync(lane_sync), .lanes_aligned(lanes_aligned),
    .tx_fault_in(tx_fault_in), .rx_err_in(rx_err_in), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/xs_mgmt_status_bench.sv
module xs_mgmt_status_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  lane_sync = 4'hF;
    logic        lanes_aligned = 1'b1;
    logic        tx_fault_in = 1'b0;
    logic        rx_err_in = 1'b0;
    logic        rd_en = 1'b0;
    logic [4:0]  rd_addr = '0;
    logic [15:0] rd_data;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    // Bench model of the latched bits (per requirements R1-style reset values).
    bit m_link = 0, m_rxf = 1, m_txf = 1;
    logic [15:0] m_out = '0;

    always #5 clk = ~clk;

    xs_mgmt_status u_xs_mgmt_status (
        .clk(clk), .rst_n(rst_n), .lane_sync(lane_sync), .lanes_aligned(lanes_aligned),
        .tx_fault_in(tx_fault_in), .rx_err_in(rx_err_in), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic bit rx_bad(logic [3:0] s, logic a, logic e);
        return (s != 4'hF) || !a || e;
    endfunction

    function automatic logic [15:0] exp_word(logic [4:0] ad, logic [3:0] s, logic a);
        logic [15:0] w = '0;
        if (ad == 5'd1) begin w[2] = m_link; w[7] = m_rxf | m_txf; end
        else if (ad == 5'd8) begin w[10] = m_rxf; w[11] = m_txf; end
        else if (ad == 5'd24) begin w[3:0] = s; w[12] = a; end
        return w;
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: rd_data=%h expected %h", req, act, exp);
        end
    endtask

    // One clock: drive after negedge, model the edge, compare at next negedge.
    task automatic step(logic [3:0] s, logic a, logic tf, logic e,
                        logic rd, logic [4:0] ad, string req);
        bit bad;
        lane_sync = s; lanes_aligned = a; tx_fault_in = tf; rx_err_in = e;
        rd_en = rd; rd_addr = ad;
        @(posedge clk);
        bad = rx_bad(s, a, e);
        if (rd) m_out = exp_word(ad, s, a);
        m_link = (rd && ad == 5'd1) ? !bad : (m_link & !bad);
        m_rxf  = (rd && ad == 5'd8) ? bad  : (m_rxf | bad);
        m_txf  = (rd && ad == 5'd8) ? tf   : (m_txf | tf);
        @(negedge clk);
        check(req, rd_data, m_out);
    endtask

    // Watchdog: counts as a failure and still reaches the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run incomplete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check("R1 reset", rd_data, 16'h0000);
        rst_n = 1'b1;
        // R1: first reads see reset values.
        step(4'hF, 1, 0, 0, 1, 5'd1, "R1 stat1 after reset");
        check("R1 const", rd_data, 16'h0080);
        step(4'hF, 1, 0, 0, 1, 5'd8, "R1 stat2 after reset");
        check("R1 const", rd_data, 16'h0C00);
        step(4'hF, 1, 0, 0, 1, 5'd8, "R4 stat2 reloaded");
        check("R4 const", rd_data, 16'h0000);
        step(4'hF, 1, 0, 0, 1, 5'd1, "R3 link reloaded");
        check("R3 const", rd_data, 16'h0004);
        // R7: transient lane loss, then read stat1 twice before stat2.
        step(4'hB, 1, 0, 0, 0, 5'd0, "R10 hold");
        step(4'hF, 1, 0, 0, 1, 5'd1, "R3 link latched low");
        check("R3 const", rd_data, 16'h0080);
        step(4'hF, 1, 0, 0, 1, 5'd1, "R7 link up while rx fault latched");
        check("R7 const", rd_data, 16'h0084);
        step(4'hF, 1, 0, 0, 1, 5'd8, "R6 stat1 read did not clear");
        check("R6 const", rd_data, 16'h0400);
        step(4'hF, 1, 0, 0, 1, 5'd8, "R4 cleared");
        check("R4 const", rd_data, 16'h0000);
        // R5: fault during the clearing read survives.
        step(4'hF, 1, 1, 0, 1, 5'd8, "R5 read with live tx fault");
        step(4'hF, 1, 0, 0, 1, 5'd8, "R5 fault kept");
        check("R5 const", rd_data, 16'h0800);
        step(4'hF, 0, 0, 0, 1, 5'd1, "R5 link drop during read");
        step(4'hF, 1, 0, 0, 1, 5'd1, "R5 link kept low");
        check("R5 const", rd_data, 16'h0080);
        step(4'hF, 1, 0, 0, 1, 5'd8, "R4 flush");
        // R2/R8: error flag alone.
        step(4'hF, 1, 0, 1, 1, 5'd24, "R8 lane word ignores rx_err");
        check("R8 const", rd_data, 16'h100F);
        step(4'hF, 1, 0, 0, 1, 5'd8, "R2 rx_err latched");
        check("R2 const", rd_data, 16'h0400);
        // R9: unused addresses.
        step(4'h0, 0, 1, 1, 1, 5'd2, "R9 unused addr");
        step(4'h0, 0, 1, 1, 1, 5'd31, "R9 unused addr");
        check("R9 const", rd_data, 16'h0000);
        // Random traffic.
        for (int i = 0; i < 4000; i++) begin
            logic [3:0] s; logic a, tf, e, rd; logic [4:0] ad; int pick;
            bit healthy = ($urandom % 10) < 7;
            s  = healthy ? 4'hF : 4'($urandom);
            a  = healthy ? 1'b1 : 1'($urandom);
            tf = ($urandom % 12) == 0;
            e  = ($urandom % 15) == 0;
            rd = ($urandom % 5) < 2;
            pick = $urandom % 4;
            ad = (pick == 0) ? 5'd1 : (pick == 1) ? 5'd8 : (pick == 2) ? 5'd24 : 5'($urandom);
            if (!rd) step(s, a, tf, e, rd, ad, "R10 hold");
            else if (ad == 5'd1) step(s, a, tf, e, rd, ad, "R3 R6 stat1");
            else if (ad == 5'd8) step(s, a, tf, e, rd, ad, "R2 R4 R5 stat2");
            else if (ad == 5'd24) step(s, a, tf, e, rd, ad, "R8 lane");
            else step(s, a, tf, e, rd, ad, "R9 other");
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule